// File: doc/BRIEF.md
# Event Counter Unit with Chained Pairs

This block is a performance-monitoring unit. It holds eight 32-bit event counters behind a plain 32-bit register read/write port. Each counter has its own event-select register. The select code picks one of six event strobes (read hit, read miss, data-side read hit, data-side read miss, write hit, write miss) or the clock itself. A selected strobe adds at most one count per clock. Software starts and stops all counting with a global control register, and enables counters and interrupts one at a time through write-1-to-set and write-1-to-clear registers. Overflow events are collected in a sticky status register that software clears by writing 1s. A single level interrupt goes high while any flagged counter has its interrupt enabled.

Two features let software leave the counters free-running:
- **Chaining.** An odd counter can be chained to the even counter below it. It then counts the wraps of that lower counter, so the pair forms one 64-bit count.
- **Top-bit mode.** Any counter can be told to flag overflow on every change of its most significant bit instead of only on a wrap.

Global control is a three-state machine:
- **STOP** (reset state): nothing counts.
- **RUN**: counting is allowed.
- **PURGE**: lasts one cycle and zeroes every counter value.

The transitions are:
- **start** (STOP to RUN): a control write with bit 0 set and bit 1 clear.
- **halt** (RUN to STOP): a control write with both bits clear.
- **purge-request** (any state to PURGE): a control write with bit 1 set.
- **resume** (PURGE to RUN): leaving PURGE with no new control write, when the last written bit 0 was set.
- **park** (PURGE to STOP): leaving PURGE with no new control write, when the last written bit 0 was clear.

A control write made while in PURGE is handled by the same rules as in the other states.

Top module: `evt_count_unit`

## Requirements
- R1: After reset, the following hold. The control register reads 0. The enable-set and interrupt-set registers read 0. The enable-clear, interrupt-clear and overflow-status registers read 0xFF. The chain, top-bit, event-select, counter-control and counter-value registers read 0. `irq` is low.
- R2: The counter value registers are at 0x420+8n. Writing one loads the counter, and the write takes priority over an increment in the same cycle. The counter-control register at 0x120+8n stores all 32 bits. The event-select register at 0x220+8n stores bits 7:0. Any unmapped address reads 0, and a write to it has no effect.
- R3: In the enable-set (0x508) and enable-clear (0x50C) registers, bit n refers to counter n. A 1 sets or clears that enable, and a 0 leaves it unchanged. Reading the set register returns the enable mask; reading the clear register returns the inverted mask. The interrupt-enable set (0x510) and clear (0x514) registers behave the same way.
- R4: Select code 0x01 counts every clock. Code 0x20+k, for k = 0..5, counts `ev_strobe[k]`. Any other code, 0 included, counts nothing.
- R5: A counter adds 1 in a cycle only if all three hold: the unit is in RUN, its own enable bit is set, and its event is active. It never changes by more than 1 without a register write or a purge.
- R6: Control register 0x500: bit 0 is the global enable and reads back; bit 1 is the purge request. A write with bit 1 set leads to PURGE for one cycle, and every counter value is 0 in the following cycle. The machine then goes to RUN or STOP according to bit 0 of that same write.
- R7: With top-bit mode off, an increment from 0xFFFFFFFF gives 0 and sets overflow bit n.
- R8: With top-bit register 0x96C bit n set, counter n sets its overflow bit on every toggle of bit 31. This includes 0x7FFFFFFF to 0x80000000. Without the mode, that step sets no flag.
- R9: In chain register 0x718, only the odd bits are stored, so writing 0xFF reads back 0xAA. With bit n set, counter n gains 1 in the same cycle that counter n-1 wraps, provided counter n's own enable is set. Counter n's own select code is then ignored.
- R10: The overflow status register is at 0x740, with bit n for counter n. Writing 1 to a bit clears it. An overflow raised in the same cycle as that clear leaves the bit set.
- R11: `irq` is high exactly when some overflow bit and its interrupt-enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, taken at the rising edge |
| reg_addr | input | 12 | Byte address of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| ev_strobe | input | 6 | Event strobes: read hit, read miss, data read hit, data read miss, write hit, write miss |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can land on the same overflow bit in the same cycle: a counter wrapping, and software writing 1 to that bit to clear it. The bench preloads counter 6 with 0xFFFFFFFF and holds the read-hit strobe high during exactly the cycle whose edge also carries the write-1 to status bit 6. Reading the status back must show bit 6 still set. A second clear with no event pending must then show it at 0. A counter-value write that coincides with an active event is judged the same way: the loaded value must win over the increment.

// File: rtl/evcu_pkg.sv
package evcu_pkg;

    localparam int REG_AW = 12;
    localparam int SEL_W  = 8;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PURGE = 2'd2
    } unit_state_e;

    localparam logic [REG_AW-1:0] A_CTRL      = 12'h500;
    localparam logic [REG_AW-1:0] A_ENSET     = 12'h508;
    localparam logic [REG_AW-1:0] A_ENCLR     = 12'h50C;
    localparam logic [REG_AW-1:0] A_IESET     = 12'h510;
    localparam logic [REG_AW-1:0] A_IECLR     = 12'h514;
    localparam logic [REG_AW-1:0] A_CHAIN     = 12'h718;
    localparam logic [REG_AW-1:0] A_OVF       = 12'h740;
    localparam logic [REG_AW-1:0] A_TOPBIT    = 12'h96C;
    localparam logic [REG_AW-1:0] A_CCTL_BASE = 12'h120;
    localparam logic [REG_AW-1:0] A_SEL_BASE  = 12'h220;
    localparam logic [REG_AW-1:0] A_VAL_BASE  = 12'h420;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RST_BIT = 1;

    localparam logic [SEL_W-1:0] CODE_CYCLES = 8'h01;
    localparam logic [SEL_W-1:0] CODE_FIRST  = 8'h20;

    // True when addr falls on an 8-byte-strided slot of a bank of n registers.
    function automatic logic bank_hit(input logic [REG_AW-1:0] addr,
                                      input logic [REG_AW-1:0] base,
                                      input int n);
        return (addr >= base) && (addr < base + REG_AW'(8 * n)) && (addr[2:0] == 3'b000);
    endfunction

endpackage

// File: rtl/evcu_unit_fsm.sv
module evcu_unit_fsm
    import evcu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_en_bit,
    input  logic wr_rst_bit,
    output logic run,
    output logic purge,
    output logic en_flag
);

    unit_state_e state_q, state_d, wr_target;
    logic        en_q;

    // Target state implied by a control write.
    always_comb begin
        if (wr_rst_bit)     wr_target = ST_PURGE;
        else if (wr_en_bit) wr_target = ST_RUN;
        else                wr_target = ST_STOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctrl_wr) en_q <= wr_en_bit;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (ctrl_wr) state_d = wr_target;             // start / purge-request
            ST_RUN:   if (ctrl_wr) state_d = wr_target;             // halt / purge-request
            ST_PURGE: begin
                if (ctrl_wr)   state_d = wr_target;
                else if (en_q) state_d = ST_RUN;                    // resume
                else           state_d = ST_STOP;                   // park
            end
            default:           state_d = ST_STOP;
        endcase
    end

    always_comb begin
        run     = (state_q == ST_RUN);
        purge   = (state_q == ST_PURGE);
        en_flag = en_q;
    end

endmodule

// File: rtl/evcu_ctr_slice.sv
module evcu_ctr_slice
    import evcu_pkg::*;
#(
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               purge,
    input  logic               en,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] ev,
    input  logic               chain_mode,
    input  logic               carry_in,
    input  logic               wr,
    input  logic [CTR_W-1:0]   wdata,
    output logic [CTR_W-1:0]   value,
    output logic               wrap,
    output logic               msb_flip
);

    localparam int EIDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam logic [SEL_W-1:0] CODE_END = CODE_FIRST + SEL_W'(NUM_EVT);

    logic [(1 << EIDX_W)-1:0] ev_pad;
    logic [EIDX_W-1:0]        rel;
    logic                     sel_hit;
    logic                     step;

    always_comb begin
        ev_pad              = '0;
        ev_pad[NUM_EVT-1:0] = ev;
        rel                 = EIDX_W'(sel - CODE_FIRST);
        sel_hit             = 1'b0;
        if (sel == CODE_CYCLES)
            sel_hit = 1'b1;
        else if (sel >= CODE_FIRST && sel < CODE_END)
            sel_hit = ev_pad[rel];
    end

    // A software load or purge in the same cycle suppresses the increment.
    assign step     = run && en && (chain_mode ? carry_in : sel_hit) && !wr && !purge;
    assign wrap     = step && (&value);
    assign msb_flip = step && (&value[CTR_W-2:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     value <= '0;
        else if (purge) value <= '0;
        else if (wr)    value <= wdata;
        else if (step)  value <= value + CTR_W'(1);
    end

endmodule

// File: rtl/evt_count_unit.sv
module evt_count_unit
    import evcu_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 6,
    parameter int REG_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] ev_strobe,
    output logic               irq
);

    localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

    function automatic logic [NUM_CTR-1:0] odd_mask();
        logic [NUM_CTR-1:0] m;
        for (int i = 0; i < NUM_CTR; i++) m[i] = (i % 2 == 1);
        return m;
    endfunction
    localparam logic [NUM_CTR-1:0] ODD_MASK = odd_mask();

    logic [NUM_CTR-1:0]            en_q, ien_q, chain_q, topbit_q, ovf_q;
    logic [NUM_CTR-1:0]            en_inv, ien_inv, ovf_set, ovf_clr, wmask;
    logic [NUM_CTR-1:0]            wrap, msb_flip, val_wr;
    logic [SEL_W-1:0]              sel_q  [NUM_CTR];
    logic [REG_W-1:0]              cctl_q [NUM_CTR];
    logic [NUM_CTR-1:0][CTR_W-1:0] ctr_vals;

    logic                          unit_run, unit_purge, unit_en, ctrl_wr;
    logic                          hit_val, hit_cctl, hit_sel;
    logic [REG_AW-1:0]             off_val, off_cctl, off_sel;
    logic [IDX_W-1:0]              idx_val, idx_cctl, idx_sel;

    // ---------------- address decode ----------------
    assign hit_val  = bank_hit(reg_addr, A_VAL_BASE,  NUM_CTR);
    assign hit_cctl = bank_hit(reg_addr, A_CCTL_BASE, NUM_CTR);
    assign hit_sel  = bank_hit(reg_addr, A_SEL_BASE,  NUM_CTR);
    assign off_val  = reg_addr - A_VAL_BASE;
    assign off_cctl = reg_addr - A_CCTL_BASE;
    assign off_sel  = reg_addr - A_SEL_BASE;
    assign idx_val  = off_val[3 +: IDX_W];
    assign idx_cctl = off_cctl[3 +: IDX_W];
    assign idx_sel  = off_sel[3 +: IDX_W];

    assign wmask    = reg_wdata[NUM_CTR-1:0];
    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign ovf_clr  = (reg_wr && reg_addr == A_OVF) ? wmask : '0;
    assign en_inv   = ~en_q;
    assign ien_inv  = ~ien_q;

    // ---------------- global control state machine ----------------
    evcu_unit_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .wr_en_bit  (reg_wdata[CTRL_EN_BIT]),
        .wr_rst_bit (reg_wdata[CTRL_RST_BIT]),
        .run        (unit_run),
        .purge      (unit_purge),
        .en_flag    (unit_en)
    );

    // ---------------- counter slices ----------------
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic chain_sel, carry_prev;
        if (i % 2 == 1) begin : g_upper
            assign chain_sel  = chain_q[i];
            assign carry_prev = wrap[i-1];
        end else begin : g_lower
            assign chain_sel  = 1'b0;
            assign carry_prev = 1'b0;
        end

        assign val_wr[i]  = reg_wr && hit_val && (idx_val == IDX_W'(i));
        assign ovf_set[i] = topbit_q[i] ? msb_flip[i] : wrap[i];

        evcu_ctr_slice #(
            .CTR_W   (CTR_W),
            .NUM_EVT (NUM_EVT)
        ) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (unit_run),
            .purge      (unit_purge),
            .en         (en_q[i]),
            .sel        (sel_q[i]),
            .ev         (ev_strobe),
            .chain_mode (chain_sel),
            .carry_in   (carry_prev),
            .wr         (val_wr[i]),
            .wdata      (CTR_W'(reg_wdata)),
            .value      (ctr_vals[i]),
            .wrap       (wrap[i]),
            .msb_flip   (msb_flip[i])
        );
    end

    // ---------------- configuration and status registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            ien_q    <= '0;
            chain_q  <= '0;
            topbit_q <= '0;
            ovf_q    <= '1;
            for (int i = 0; i < NUM_CTR; i++) begin
                sel_q[i]  <= '0;
                cctl_q[i] <= '0;
            end
        end else begin
            if (reg_wr && reg_addr == A_ENSET)  en_q     <= en_q | wmask;
            if (reg_wr && reg_addr == A_ENCLR)  en_q     <= en_q & ~wmask;
            if (reg_wr && reg_addr == A_IESET)  ien_q    <= ien_q | wmask;
            if (reg_wr && reg_addr == A_IECLR)  ien_q    <= ien_q & ~wmask;
            if (reg_wr && reg_addr == A_CHAIN)  chain_q  <= wmask & ODD_MASK;
            if (reg_wr && reg_addr == A_TOPBIT) topbit_q <= wmask;
            if (reg_wr && hit_sel)  sel_q[idx_sel]   <= reg_wdata[SEL_W-1:0];
            if (reg_wr && hit_cctl) cctl_q[idx_cctl] <= reg_wdata;
            ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata = '0;
        if (hit_val)
            reg_rdata = REG_W'(ctr_vals[idx_val]);
        else if (hit_cctl)
            reg_rdata = cctl_q[idx_cctl];
        else if (hit_sel)
            reg_rdata = REG_W'(sel_q[idx_sel]);
        else begin
            unique case (reg_addr)
                A_CTRL:   reg_rdata[CTRL_EN_BIT] = unit_en;
                A_ENSET:  reg_rdata = REG_W'(en_q);
                A_ENCLR:  reg_rdata = REG_W'(en_inv);
                A_IESET:  reg_rdata = REG_W'(ien_q);
                A_IECLR:  reg_rdata = REG_W'(ien_inv);
                A_CHAIN:  reg_rdata = REG_W'(chain_q);
                A_TOPBIT: reg_rdata = REG_W'(topbit_q);
                A_OVF:    reg_rdata = REG_W'(ovf_q);
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign irq = |(ovf_q & ien_q);

endmodule

// File: rtl/evcu_props.sv
module evcu_props
    import evcu_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic [REG_AW-1:0]             reg_addr,
    input logic                          irq,
    input logic [NUM_CTR-1:0]            ovf_q,
    input logic [NUM_CTR-1:0]            ien_q,
    input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_vals,
    input logic                          run,
    input logic                          purge
);

    // R10: status bits only drop through a write to the status register
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_OVF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    // R6: the cycle after the purge state every counter reads zero
    p_purge_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> (ctr_vals == '0));

    // R6: purge lasts one cycle unless a new control write arrives
    p_purge_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (purge && !reg_wr) |=> !purge);

    // R5: outside RUN, without writes, counters hold
    p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !purge && !reg_wr) |=> $stable(ctr_vals));

    // R11: no interrupt without an enabled source
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

    // R5: a counter advances by at most one per cycle
    for (genvar k = 0; k < NUM_CTR; k++) begin : g_step
        p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_wr && !purge) |=>
                (ctr_vals[k] == $past(ctr_vals[k]) ||
                 ctr_vals[k] == $past(ctr_vals[k]) + CTR_W'(1)));
    end

endmodule

bind evt_count_unit evcu_props #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W)
) u_props (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .irq      (irq),
    .ovf_q    (ovf_q),
    .ien_q    (ien_q),
    .ctr_vals (ctr_vals),
    .run      (unit_run),
    .purge    (unit_purge)
);

// File: tb/evt_count_unit_test.sv
`timescale 1ns/1ps
module evt_count_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [5:0]  ev_strobe;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    evt_count_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_strobe (ev_strobe),
        .irq       (irq)
    );

    localparam logic [11:0] CTRL = 12'h500, ENSET = 12'h508, ENCLR = 12'h50C;
    localparam logic [11:0] IESET = 12'h510, IECLR = 12'h514, CHAIN = 12'h718;
    localparam logic [11:0] OVF = 12'h740, TOPB = 12'h96C;

    function automatic logic [11:0] val_a(input int n); return 12'h420 + 12'(8 * n); endfunction
    function automatic logic [11:0] sel_a(input int n); return 12'h220 + 12'(8 * n); endfunction

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] ex;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{12'h220, 32'h000001A5, 12'h220, 32'h000000A5, 4'd2},   // R2 select keeps 8 bits
        '{12'h138, 32'hDEADBEEF, 12'h138, 32'hDEADBEEF, 4'd2},   // R2 control keeps 32 bits
        '{12'h430, 32'h12345678, 12'h430, 32'h12345678, 4'd2},   // R2 counter load
        '{12'h004, 32'hFFFFFFFF, 12'h004, 32'h00000000, 4'd2},   // R2 unmapped
        '{12'h508, 32'h0000000F, 12'h508, 32'h0000000F, 4'd3},   // R3 set
        '{12'h50C, 32'h00000000, 12'h50C, 32'h000000F0, 4'd3},   // R3 zeros ignored, clear reads inverse
        '{12'h50C, 32'h00000005, 12'h508, 32'h0000000A, 4'd3},   // R3 clear
        '{12'h508, 32'h00000000, 12'h508, 32'h0000000A, 4'd3},   // R3 zeros ignored
        '{12'h510, 32'h00000081, 12'h510, 32'h00000081, 4'd3},   // R3 interrupt set
        '{12'h514, 32'h00000080, 12'h514, 32'h000000FE, 4'd3},   // R3 interrupt clear
        '{12'h718, 32'h000000FF, 12'h718, 32'h000000AA, 4'd9},   // R9 odd bits only
        '{12'h96C, 32'h0000003C, 12'h96C, 32'h0000003C, 4'd8},   // R8 top-bit register
        '{12'h740, 32'h0000000F, 12'h740, 32'h000000F0, 4'd10}   // R10 write-1-clear
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [5:0] e, input int cyc);
        ev_strobe = e;
        repeat (cyc) @(negedge clk);
        ev_strobe = '0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, keep;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; ev_strobe = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // ---------------- R1 reset state ----------------
        rd(CTRL, v);     chk("R1 ctrl", v, 32'h0);
        rd(ENSET, v);    chk("R1 enable set", v, 32'h0);
        rd(ENCLR, v);    chk("R1 enable clear", v, 32'hFF);
        rd(IECLR, v);    chk("R1 int clear", v, 32'hFF);
        rd(OVF, v);      chk("R1 overflow status", v, 32'hFF);
        rd(CHAIN, v);    chk("R1 chain", v, 32'h0);
        rd(sel_a(5), v); chk("R1 select", v, 32'h0);
        rd(val_a(7), v); chk("R1 counter", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // ---------------- register table ----------------
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].wa, VEC[i].wd);
            rd(VEC[i].ra, v);
            chk($sformatf("R%0d table row %0d", VEC[i].req, i), v, VEC[i].ex);
        end
        wr(CHAIN, 0); wr(TOPB, 0); wr(IECLR, 32'hFF); wr(ENCLR, 32'hFF); wr(OVF, 32'hFF);

        // ---------------- R4 cycle code, R2 write priority ----------------
        wr(sel_a(0), 32'h01); wr(sel_a(2), 32'h00);
        wr(CTRL, 32'h1); wr(ENSET, 32'h05);
        wr(val_a(0), 0);                    // load wins over the cycle increment
        repeat (5) @(negedge clk);
        rd(val_a(0), v); chk("R4 cycle code counts 5", v, 32'd5);
        rd(val_a(2), v); chk("R4 code 0 counts nothing", v, 32'h12345678);

        // ---------------- R6 purge ----------------
        wr(CTRL, 32'h3);
        @(negedge clk);
        rd(val_a(0), v); chk("R6 purge zeroes counter 0", v, 32'h0);
        rd(val_a(2), v); chk("R6 purge zeroes counter 2", v, 32'h0);
        @(negedge clk);
        rd(val_a(0), v); chk("R6 resumes counting", v, 32'h1);
        rd(CTRL, v);     chk("R6 enable readback", v, 32'h1);

        // ---------------- R5 gating ----------------
        wr(CTRL, 32'h0);
        rd(val_a(0), keep);
        repeat (4) @(negedge clk);
        rd(val_a(0), v); chk("R5 global stop holds", v, keep);
        wr(ENCLR, 32'h01); wr(CTRL, 32'h1);
        rd(val_a(0), keep);
        repeat (4) @(negedge clk);
        rd(val_a(0), v); chk("R5 own enable off holds", v, keep);
        wr(ENCLR, 32'hFF);

        // ---------------- R4 strobe mapping ----------------
        wr(sel_a(0), 32'h20); wr(sel_a(1), 32'h25); wr(sel_a(2), 32'h22); wr(sel_a(3), 32'h26);
        for (int k = 0; k < 4; k++) wr(val_a(k), 0);
        wr(ENSET, 32'h0F);
        pulse(6'b100001, 3);
        pulse(6'b000100, 2);
        rd(val_a(0), v); chk("R4 code 0x20 -> strobe 0", v, 32'd3);
        rd(val_a(1), v); chk("R4 code 0x25 -> strobe 5", v, 32'd3);
        rd(val_a(2), v); chk("R4 code 0x22 -> strobe 2", v, 32'd2);
        rd(val_a(3), v); chk("R4 code 0x26 counts nothing", v, 32'd0);

        // ---------------- R7 wrap ----------------
        wr(ENCLR, 32'hFF); wr(OVF, 32'hFF);
        wr(val_a(3), 32'hFFFFFFFF); wr(sel_a(3), 32'h20); wr(ENSET, 32'h08);
        pulse(6'b000001, 1);
        rd(val_a(3), v); chk("R7 wrap to zero", v, 32'h0);
        rd(OVF, v);      chk("R7 wrap flag", v, 32'h08);

        // ---------------- R8 top-bit mode ----------------
        wr(ENCLR, 32'hFF); wr(OVF, 32'hFF); wr(TOPB, 32'h10);
        wr(val_a(4), 32'h7FFFFFFF); wr(val_a(5), 32'h7FFFFFFF);
        wr(sel_a(4), 32'h20); wr(sel_a(5), 32'h20); wr(ENSET, 32'h30);
        pulse(6'b000001, 1);
        rd(val_a(4), v); chk("R8 counter 4 value", v, 32'h80000000);
        rd(OVF, v);      chk("R8 flag only in top-bit mode", v, 32'h10);

        // ---------------- R9 chaining ----------------
        wr(ENCLR, 32'hFF); wr(OVF, 32'hFF); wr(TOPB, 0); wr(CHAIN, 32'h02);
        wr(val_a(0), 32'hFFFFFFFE); wr(val_a(1), 32'd5);
        wr(sel_a(0), 32'h20); wr(sel_a(1), 32'h21); wr(ENSET, 32'h03);
        pulse(6'b000011, 3);
        rd(val_a(0), v); chk("R9 lower half", v, 32'd1);
        rd(val_a(1), v); chk("R9 upper counts one carry", v, 32'd6);
        rd(OVF, v);      chk("R9 only lower wrap flagged", v, 32'h01);
        wr(CHAIN, 0);
        pulse(6'b000010, 1);
        rd(val_a(1), v); chk("R9 unchained uses own select", v, 32'd7);

        // ---------------- R10 clear vs new overflow in same cycle ----------------
        wr(ENCLR, 32'hFF); wr(OVF, 32'hFF);
        wr(val_a(6), 32'hFFFFFFFF); wr(sel_a(6), 32'h20); wr(ENSET, 32'h40);
        ev_strobe = 6'b000001;
        wr(OVF, 32'h40);
        ev_strobe = '0;
        rd(OVF, v); chk("R10 set wins over clear", v, 32'h40);
        wr(OVF, 32'h40);
        rd(OVF, v); chk("R10 write-1 clears", v, 32'h00);

        // ---------------- R11 interrupt ----------------
        wr(val_a(6), 32'hFFFFFFFF);
        pulse(6'b000001, 1);
        chk("R11 no irq without enable", {31'b0, irq}, 32'h0);
        wr(IESET, 32'h40);
        chk("R11 irq raised", {31'b0, irq}, 32'h1);
        wr(IECLR, 32'h40);
        chk("R11 irq dropped by enable clear", {31'b0, irq}, 32'h0);
        wr(IESET, 32'h41);
        wr(OVF, 32'h40);
        chk("R11 irq dropped by status clear", {31'b0, irq}, 32'h0);

        summary();
        $finish;
    end

endmodule